// File: doc/BRIEF.md
# DMA Staging Buffer with Fill-Level Service Requests

This block sits between a narrow I/O stream port that moves one 4-byte word per cycle and a wide memory port that moves 32-byte units. It holds up to 128 bytes. Each transfer is started in one of two directions. In a write transfer the I/O side fills the buffer and memory drains it. In a read transfer memory fills the buffer and the I/O side drains it. Transfers can be longer than the buffer, for example 512 bytes, so the buffer refills or drains several times during one transfer.

The block does not hold memory for the whole transfer. It raises a service request only when its fill level crosses a watermark, so other users can reach memory between bursts. A read stream has no length given in advance. It runs for as long as the I/O side holds its read request. The block delays the first word until enough data is buffered that the stream can run without gaps. At the end of a write transfer, any partly filled unit is written out with per-byte enables, and a one-cycle completion pulse is raised.

Top module: `dma_stage_buf`

## Requirements
- R1: After reset the block is idle: `mem_req`, `io_wready`, `io_rvalid` and `xfer_done` are all low.
- R2: In a write transfer, `io_wready` is high exactly while fewer than 32 words (128 bytes) are held and the last word has not yet been accepted. Accepted words are kept in arrival order.
- R3: In a write transfer, before the last word is accepted, `mem_req` is high exactly while 96 bytes (24 words) or more are held.
- R4: A cycle with `mem_gnt` and `mem_req` both high during a write transfer removes the 8 oldest words. They are presented on `mem_wdata`, with the oldest word in bits [31:0] and word k in bits [32k+31:32k]. Each word's 4 stored byte enables appear in `mem_wbe` bits [4k+3:4k].
- R5: `mem_gnt` has no effect in a cycle where `mem_req` is low, in either direction and when idle.
- R6: Once the word marked `io_wlast` is accepted, `mem_req` stays high while any data remains. A final unit with fewer than 8 words carries zero enables in the lanes past the last held word. `xfer_done` pulses for one cycle in the cycle after the last unit leaves, and the block is idle from then on.
- R7: In a read transfer, `mem_req` is high exactly while 32 bytes (8 words) or fewer are held. A granted cycle appends `mem_rdata` as the next 8 words, with word k taken from bits [32k+31:32k].
- R8: In a read transfer, `io_rvalid` stays low until at least 64 bytes (16 words) have been held. It rises in the first cycle that level is reached.
- R9: Once streaming has begun, and while `io_rreq` stays high, `io_rvalid` stays high with no gaps and `io_rdata` returns the fetched words in order. This holds provided memory grants each request within 7 cycles.
- R10: Dropping `io_rreq` while streaming ends the read transfer. `xfer_done` pulses in the next cycle, buffered data is discarded, and the block becomes idle.
- R11: `xfer_start` is ignored while a transfer is in progress. The direction of the running transfer does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Starts a transfer when the block is idle |
| xfer_is_read | input | 1 | Direction sampled with `xfer_start`: 1 = memory to I/O |
| io_wvalid | input | 1 | Write data word is present |
| io_wdata | input | 32 | Write data word |
| io_wbe | input | 4 | Byte enables of the write data word |
| io_wlast | input | 1 | Marks the final word of a write transfer |
| io_wready | output | 1 | Buffer accepts a write word this cycle |
| io_rreq | input | 1 | Read stream request, held for the stream's length |
| io_rvalid | output | 1 | Read data word is present |
| io_rdata | output | 32 | Read data word |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |
| mem_req | output | 1 | Fill-level service request to memory |
| mem_gnt | input | 1 | Memory moves one unit this cycle |
| mem_wdata | output | 256 | Unit being drained to memory |
| mem_wbe | output | 32 | Byte enables of the drained unit |
| mem_rdata | input | 256 | Unit being filled from memory |

## Verification
A fill count that drifts by even one word shows up at the ports within a cycle or two. The edge of `mem_req` moves away from the bench's 24-word or 8-word level, `io_wready` drops early or late, or `io_rvalid` rises before or after the 16-word point. A pointer error shows up as wrong words on `mem_wdata` or `io_rdata` at the next unit boundary or read beat. A missed or spurious end-of-transfer shows up as a `xfer_done` pulse in the wrong cycle. Sweeping every transfer length from 1 to 40 words, plus a long one, places the final partial unit at every offset within a unit. Different grant policies exercise the full buffer, ignored grants and prompt service.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WFILL   = 3'd1,
        ST_WFLUSH  = 3'd2,
        ST_RFILL   = 3'd3,
        ST_RSTREAM = 3'd4
    } dsb_state_e;
endpackage

// File: rtl/dsb_watermark.sv
module dsb_watermark
    import dsb_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int HI_W  = 24,
    parameter int LO_W  = 8
) (
    input  dsb_state_e       st,
    input  logic [CNT_W-1:0] cnt,
    output logic             svc_req
);
    logic over_hi, under_lo, nonempty;

    assign over_hi  = cnt >= CNT_W'(HI_W);
    assign under_lo = cnt <= CNT_W'(LO_W);
    assign nonempty = cnt != '0;

    always_comb begin
        case (st)
            ST_WFILL:              svc_req = over_hi;
            ST_WFLUSH:             svc_req = nonempty;
            ST_RFILL, ST_RSTREAM:  svc_req = under_lo;
            default:               svc_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/dsb_unit_view.sv
module dsb_unit_view #(
    parameter int DEPTH_WORDS = 32,
    parameter int WORD_BYTES  = 4,
    parameter int UNIT_WORDS  = 8,
    parameter int PTR_W       = 5,
    parameter int CNT_W       = 6
) (
    input  logic [DEPTH_WORDS-1:0][WORD_BYTES*8-1:0] dat,
    input  logic [DEPTH_WORDS-1:0][WORD_BYTES-1:0]   be,
    input  logic [PTR_W-1:0]                         base,
    input  logic [CNT_W-1:0]                         cnt,
    output logic [UNIT_WORDS*WORD_BYTES*8-1:0]       unit_data,
    output logic [UNIT_WORDS*WORD_BYTES-1:0]         unit_be
);
    localparam int WORD_W = WORD_BYTES * 8;

    for (genvar k = 0; k < UNIT_WORDS; k++) begin : g_lane
        logic [PTR_W-1:0] idx;
        logic             lane_on;
        assign idx     = base + PTR_W'(k);
        assign lane_on = cnt > CNT_W'(k);
        assign unit_data[k*WORD_W +: WORD_W]         = dat[idx];
        assign unit_be[k*WORD_BYTES +: WORD_BYTES]   = lane_on ? be[idx] : '0;
    end
endmodule

// File: rtl/dma_stage_buf.sv
module dma_stage_buf
    import dsb_pkg::*;
#(
    parameter int WORD_BYTES  = 4,
    parameter int UNIT_WORDS  = 8,
    parameter int DEPTH_WORDS = 32,
    parameter int WR_HI_BYTES = 96,
    parameter int RD_LO_BYTES = 32,
    parameter int RD_GO_BYTES = 64
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  xfer_start,
    input  logic                                  xfer_is_read,
    input  logic                                  io_wvalid,
    input  logic [WORD_BYTES*8-1:0]               io_wdata,
    input  logic [WORD_BYTES-1:0]                 io_wbe,
    input  logic                                  io_wlast,
    output logic                                  io_wready,
    input  logic                                  io_rreq,
    output logic                                  io_rvalid,
    output logic [WORD_BYTES*8-1:0]               io_rdata,
    output logic                                  xfer_done,
    output logic                                  mem_req,
    input  logic                                  mem_gnt,
    output logic [UNIT_WORDS*WORD_BYTES*8-1:0]    mem_wdata,
    output logic [UNIT_WORDS*WORD_BYTES-1:0]      mem_wbe,
    input  logic [UNIT_WORDS*WORD_BYTES*8-1:0]    mem_rdata
);
    localparam int WORD_W  = WORD_BYTES * 8;
    localparam int PTR_W   = $clog2(DEPTH_WORDS);
    localparam int CNT_W   = PTR_W + 1;
    localparam int WR_HI_W = WR_HI_BYTES / WORD_BYTES;
    localparam int RD_LO_W = RD_LO_BYTES / WORD_BYTES;
    localparam int RD_GO_W = RD_GO_BYTES / WORD_BYTES;

    typedef struct packed {
        dsb_state_e                            st;
        logic [PTR_W-1:0]                      wp;
        logic [PTR_W-1:0]                      rp;
        logic [CNT_W-1:0]                      cnt;
        logic                                  done;
        logic [DEPTH_WORDS-1:0][WORD_W-1:0]    dat;
        logic [DEPTH_WORDS-1:0][WORD_BYTES-1:0] be;
    } regs_t;

    regs_t r_q, r_d;

    logic             svc_req;
    logic             gnt_ok;
    logic             wr_room;
    logic             push, pop;
    logic [CNT_W-1:0] unit_take;
    logic [CNT_W-1:0] cnt_nx;

    // visible to the bound checker
    logic [CNT_W-1:0] fill_words;
    dsb_state_e       st_q;
    assign fill_words = r_q.cnt;
    assign st_q       = r_q.st;

    dsb_watermark #(
        .CNT_W (CNT_W),
        .HI_W  (WR_HI_W),
        .LO_W  (RD_LO_W)
    ) u_wm (
        .st      (r_q.st),
        .cnt     (r_q.cnt),
        .svc_req (svc_req)
    );

    dsb_unit_view #(
        .DEPTH_WORDS (DEPTH_WORDS),
        .WORD_BYTES  (WORD_BYTES),
        .UNIT_WORDS  (UNIT_WORDS),
        .PTR_W       (PTR_W),
        .CNT_W       (CNT_W)
    ) u_view (
        .dat       (r_q.dat),
        .be        (r_q.be),
        .base      (r_q.rp),
        .cnt       (r_q.cnt),
        .unit_data (mem_wdata),
        .unit_be   (mem_wbe)
    );

    assign gnt_ok    = mem_gnt && svc_req;
    assign wr_room   = r_q.cnt < CNT_W'(DEPTH_WORDS);
    assign unit_take = (r_q.cnt >= CNT_W'(UNIT_WORDS)) ? CNT_W'(UNIT_WORDS) : r_q.cnt;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        push     = 1'b0;
        pop      = 1'b0;
        cnt_nx   = r_q.cnt;
        case (r_q.st)
            ST_IDLE: begin
                if (xfer_start) begin
                    r_d.wp  = '0;
                    r_d.rp  = '0;
                    r_d.cnt = '0;
                    r_d.st  = xfer_is_read ? ST_RFILL : ST_WFILL;
                end
            end
            ST_WFILL, ST_WFLUSH: begin
                push = (r_q.st == ST_WFILL) && io_wvalid && wr_room;
                if (push) begin
                    r_d.dat[r_q.wp] = io_wdata;
                    r_d.be[r_q.wp]  = io_wbe;
                    r_d.wp          = r_q.wp + PTR_W'(1);
                    cnt_nx          = cnt_nx + CNT_W'(1);
                end
                if (gnt_ok) begin
                    r_d.rp = r_q.rp + PTR_W'(UNIT_WORDS);
                    cnt_nx = cnt_nx - unit_take;
                end
                r_d.cnt = cnt_nx;
                if (push && io_wlast) begin
                    r_d.st = ST_WFLUSH;
                end
                if ((r_q.st == ST_WFLUSH) && gnt_ok && (cnt_nx == '0)) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            ST_RFILL, ST_RSTREAM: begin
                pop = (r_q.st == ST_RSTREAM) && io_rreq && (r_q.cnt != '0);
                if (gnt_ok) begin
                    for (int k = 0; k < UNIT_WORDS; k++) begin
                        r_d.dat[r_q.wp + PTR_W'(k)] = mem_rdata[k*WORD_W +: WORD_W];
                    end
                    r_d.wp = r_q.wp + PTR_W'(UNIT_WORDS);
                    cnt_nx = cnt_nx + CNT_W'(UNIT_WORDS);
                end
                if (pop) begin
                    r_d.rp = r_q.rp + PTR_W'(1);
                    cnt_nx = cnt_nx - CNT_W'(1);
                end
                r_d.cnt = cnt_nx;
                if ((r_q.st == ST_RFILL) && (cnt_nx >= CNT_W'(RD_GO_W))) begin
                    r_d.st = ST_RSTREAM;
                end
                if ((r_q.st == ST_RSTREAM) && !io_rreq) begin
                    r_d.st   = ST_IDLE;
                    r_d.cnt  = '0;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req   = svc_req;
    assign io_wready = (r_q.st == ST_WFILL) && wr_room;
    assign io_rvalid = (r_q.st == ST_RSTREAM) && (r_q.cnt != '0);
    assign io_rdata  = r_q.dat[r_q.rp];
    assign xfer_done = r_q.done;
endmodule

// File: rtl/dsb_checker.sv
module dsb_checker
    import dsb_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int DEPTH_WORDS = 32,
    parameter int UNIT_WORDS  = 8,
    parameter int RD_LO_W     = 8,
    parameter int RD_GO_W     = 16
) (
    input logic             clk,
    input logic             rst_n,
    input dsb_state_e       st_q,
    input logic [CNT_W-1:0] fill_words,
    input logic             mem_req,
    input logic             mem_gnt,
    input logic             io_wvalid,
    input logic             io_wready,
    input logic             io_rreq,
    input logic             io_rvalid,
    input logic             xfer_done
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill_words <= CNT_W'(DEPTH_WORDS)); // R2
    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_words == CNT_W'(DEPTH_WORDS)) |-> !io_wready); // R2
    AST_DRAIN_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WFILL && mem_req && mem_gnt && !io_wvalid)
        |=> fill_words == $past(fill_words) - CNT_W'(UNIT_WORDS)); // R4
    AST_IDLE_GNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WFILL && mem_gnt && !mem_req && !io_wvalid) |=> $stable(fill_words)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done); // R6
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!mem_req && !io_wready && !io_rvalid)); // R10
    AST_LOW_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rvalid && fill_words <= CNT_W'(RD_LO_W)) |-> mem_req); // R7
    AST_STREAM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_rvalid) |-> fill_words >= CNT_W'(RD_GO_W)); // R8
    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rvalid && io_rreq && fill_words > CNT_W'(1)) |=> io_rvalid); // R9
endmodule

bind dma_stage_buf dsb_checker #(
    .CNT_W       (CNT_W),
    .DEPTH_WORDS (DEPTH_WORDS),
    .UNIT_WORDS  (UNIT_WORDS),
    .RD_LO_W     (RD_LO_W),
    .RD_GO_W     (RD_GO_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_q       (st_q),
    .fill_words (fill_words),
    .mem_req    (mem_req),
    .mem_gnt    (mem_gnt),
    .io_wvalid  (io_wvalid),
    .io_wready  (io_wready),
    .io_rreq    (io_rreq),
    .io_rvalid  (io_rvalid),
    .xfer_done  (xfer_done)
);

// File: tb/dma_stage_buf_bench.sv
module dma_stage_buf_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         xfer_start = 1'b0;
    logic         xfer_is_read = 1'b0;
    logic         io_wvalid = 1'b0;
    logic [31:0]  io_wdata = '0;
    logic [3:0]   io_wbe = '0;
    logic         io_wlast = 1'b0;
    logic         io_wready;
    logic         io_rreq = 1'b0;
    logic         io_rvalid;
    logic [31:0]  io_rdata;
    logic         xfer_done;
    logic         mem_req;
    logic         mem_gnt = 1'b0;
    logic [255:0] mem_wdata;
    logic [31:0]  mem_wbe;
    logic [255:0] mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dma_stage_buf u_dma_stage_buf (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_is_read(xfer_is_read),
        .io_wvalid(io_wvalid), .io_wdata(io_wdata), .io_wbe(io_wbe), .io_wlast(io_wlast),
        .io_wready(io_wready), .io_rreq(io_rreq), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
        .xfer_done(xfer_done), .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_wdata(mem_wdata), .mem_wbe(mem_wbe), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] wdat(int n, int i);
        return {n[7:0], 8'hC3, i[15:0]};
    endfunction
    function automatic logic [31:0] rdat(int n, int i);
        return {n[7:0], 8'h5A, i[15:0]};
    endfunction
    function automatic logic [3:0] lbe(int n);
        return 4'(n % 15 + 1);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic do_write(input int n, input int pol);
        int sent = 0, drained = 0, held = 0, drn_p = 0;
        bit ended = 0, acc_p = 0, full_seen = 0, spur = 0, gnt;
        logic [255:0] ew, mask;
        logic [31:0]  eb;
        string tag;
        @(negedge clk);
        xfer_start = 1'b1; xfer_is_read = 1'b0;
        @(negedge clk);
        // R11: a held start with the other direction must not disturb the transfer
        xfer_start = (n == 3); xfer_is_read = (n == 3);
        while (1) begin
            if (acc_p) begin sent++; held++; if (sent == n) ended = 1; end
            if (drn_p > 0) begin held -= drn_p; drained += 8; end
            acc_p = 0; drn_p = 0;
            if (ended && held == 0) begin
                chk(xfer_done == 1'b1, "R6", "done pulse after last unit", 256'(xfer_done), 256'(1));
                chk(io_wready == 1'b0, "R6", "idle after flush", 256'(io_wready), 256'(0));
                break;
            end
            tag = spur ? "R5" : (ended ? "R6" : "R3");
            chk(io_wready == (!ended && held < 32), "R2", "wready vs held words",
                256'(io_wready), 256'(!ended && held < 32));
            chk(mem_req == (ended ? (held > 0) : (held >= 24)), tag, "mem_req vs held words",
                256'(mem_req), 256'(ended ? (held > 0) : (held >= 24)));
            if (n == 3) chk(io_rvalid == 1'b0, "R11", "direction kept", 256'(io_rvalid), 256'(0));
            if (held == 32) full_seen = 1;
            if (mem_req) begin
                ew = '0; mask = '0; eb = '0;
                for (int k = 0; k < 8; k++) begin
                    if (k < held) begin
                        ew[k*32 +: 32]   = wdat(n, drained + k);
                        mask[k*32 +: 32] = '1;
                        eb[k*4 +: 4]     = (drained + k == n - 1) ? lbe(n) : 4'hF;
                    end
                end
                chk((mem_wdata & mask) == ew, ended ? "R6" : "R4", "drained unit data", mem_wdata & mask, ew);
                chk(mem_wbe == eb, ended ? "R6" : "R4", "drained unit enables", 256'(mem_wbe), 256'(eb));
            end
            if (pol == 1) gnt = 1;
            else if (pol == 2 && !full_seen && !ended) gnt = 0;
            else gnt = mem_req;
            mem_gnt = gnt;
            spur = gnt && !mem_req;
            drn_p = (gnt && mem_req) ? ((held < 8) ? held : 8) : 0;
            if (io_wready && sent < n) begin
                io_wvalid = 1'b1;
                io_wdata  = wdat(n, sent);
                io_wbe    = (sent == n - 1) ? lbe(n) : 4'hF;
                io_wlast  = (sent == n - 1);
                acc_p     = 1;
            end else begin
                io_wvalid = 1'b0; io_wlast = 1'b0;
            end
            @(negedge clk);
        end
        xfer_start = 1'b0; xfer_is_read = 1'b0; io_wvalid = 1'b0; io_wlast = 1'b0;
        mem_gnt = (pol == 1);
        @(negedge clk);
        chk(xfer_done == 1'b0, "R6", "done lasts one cycle", 256'(xfer_done), 256'(0));
        chk(mem_req == 1'b0, "R5", "no request when idle", 256'(mem_req), 256'(0));
        mem_gnt = 1'b0;
    endtask

    task automatic do_read(input int len, input int pol);
        int fills = 0, held = 0, popped = 0;
        bit fill_p = 0, pop_p = 0, streaming = 0, dropped = 0, spur = 0, gnt;
        @(negedge clk);
        xfer_start = 1'b1; xfer_is_read = 1'b1; io_rreq = 1'b1;
        @(negedge clk);
        xfer_start = (len == 5); xfer_is_read = !(len == 5);
        while (1) begin
            if (fill_p) begin held += 8; fills++; end
            if (pop_p) begin held--; popped++; end
            fill_p = 0; pop_p = 0;
            if (dropped) begin
                chk(xfer_done == 1'b1, "R10", "done after request drop", 256'(xfer_done), 256'(1));
                chk(io_rvalid == 1'b0, "R10", "stream stopped", 256'(io_rvalid), 256'(0));
                chk(mem_req == 1'b0, "R10", "buffer discarded", 256'(mem_req), 256'(0));
                break;
            end
            if (!streaming && held >= 16) streaming = 1;
            chk(io_rvalid == (streaming && held > 0), streaming ? "R9" : "R8", "rvalid timing",
                256'(io_rvalid), 256'(streaming && held > 0));
            chk(mem_req == (held <= 8), spur ? "R5" : "R7", "mem_req vs held words",
                256'(mem_req), 256'(held <= 8));
            if (io_rvalid)
                chk(io_rdata == rdat(len, popped), "R9", "read word order", 256'(io_rdata), 256'(rdat(len, popped)));
            if (len == 5) chk(io_wready == 1'b0, "R11", "direction kept", 256'(io_wready), 256'(0));
            gnt = (pol == 1) ? 1'b1 : mem_req;
            mem_gnt = gnt;
            spur = gnt && !mem_req;
            for (int k = 0; k < 8; k++) mem_rdata[k*32 +: 32] = rdat(len, fills * 8 + k);
            fill_p = gnt && mem_req;
            if (popped < len) begin
                io_rreq = 1'b1;
                pop_p = io_rvalid;
            end else begin
                io_rreq = 1'b0; xfer_start = 1'b0; dropped = 1; fill_p = 0;
            end
            @(negedge clk);
        end
        xfer_start = 1'b0; io_rreq = 1'b0;
        mem_gnt = (pol == 1);
        @(negedge clk);
        chk(xfer_done == 1'b0, "R10", "done lasts one cycle", 256'(xfer_done), 256'(0));
        chk(mem_req == 1'b0, "R5", "idle grant ignored", 256'(mem_req), 256'(0));
        mem_gnt = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req == 1'b0, "R1", "reset mem_req", 256'(mem_req), 256'(0));
        chk(io_wready == 1'b0, "R1", "reset wready", 256'(io_wready), 256'(0));
        chk(io_rvalid == 1'b0, "R1", "reset rvalid", 256'(io_rvalid), 256'(0));
        chk(xfer_done == 1'b0, "R1", "reset done", 256'(xfer_done), 256'(0));
        mem_gnt = 1'b1;
        repeat (3) @(negedge clk);
        chk(mem_req == 1'b0 && xfer_done == 1'b0, "R5", "idle grant ignored",
            256'({mem_req, xfer_done}), 256'(0));
        mem_gnt = 1'b0;
        for (int n = 1; n <= 40; n++) do_write(n, n % 3);
        do_write(128, 0);
        for (int n = 1; n <= 40; n++) do_read(n, n % 2);
        do_read(128, 0);
        do_write(37, 2);
        summary();
    end
endmodule